// File: doc/BRIEF.md
# Flash Read Responder with Status and Identification Modes

This block answers every bus read aimed at a parallel NOR flash device. A separate command decoder tracks the unlock and command write cycles and presents the current read mode. This block turns that mode and the read offset into a registered data word. It can return plain array bytes packed for a 1-, 2- or 4-byte access in either byte order. It can also return identification words, entries from an external query table, or the embedded-operation status byte.

The block owns the status byte. A completed program sets the status byte from the programmed data. Each status read flips one bit, so software polling the device sees a toggle. An erase clears the status and starts a busy timer. A sector erase runs for a parameterised number of clock cycles, and a chip erase runs five times as long. When the timer expires, the block flips the completion bit. It also pulses an end signal that tells the decoder whether to resume the bypass command-wait state or plain read mode.

The query table is an external ROM. The block drives its index and takes its byte back in the same cycle. The array works the same way: it presents the four bytes starting at the read offset.

Top module: `flash_rd_resp`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, rd_data_o is 0, rd_vld_o is 0, busy_o is 0, erase_end_o is 0, and the internal status byte is 0x00.
- R2: rd_vld_o is high in exactly the cycle after a cycle with rd_stb_i high. rd_data_o is loaded only then and holds its value otherwise.
- R3: In mode 0 (array), byte k of arr_data_i (bits 8k+7..8k) is the byte at offset+k. Size code 0 returns byte 0. Size code 1 returns two bytes and size codes 2 and 3 return four bytes. When big_end_i is 1, the lowest-addressed byte is placed in the most significant position; otherwise it is placed in the least significant position. All unused upper bits are zero.
- R4: In mode 1 (identification), the word index is the offset divided by BUS_BYTES. Index 0 returns MFR_ID, index 1 returns DEV_ID, and index 2 returns 0, meaning no sector is protected.
- R5: In mode 1, index 0x0E returns EXT_ID_A and index 0x0F returns EXT_ID_B. When the relevant parameter equals 0x00FF, that index returns array data as in R3 instead. Array data is also returned at every other index above 2.
- R6: cfi_idx_o equals rd_off_i divided by BUS_BYTES. In mode 2 (query), a read returns cfi_byte_i zero-extended when the index is below CFI_LEN, and returns 0 otherwise.
- R7: In mode 3 (status), each cycle with rd_stb_i high returns the status byte zero-extended and then inverts status bit 6.
- R8: A prog_done_i pulse sets status bit 7 to the complement of prog_msb_i and sets bits 6..0 to 1.
- R9: An accepted erase_go_i clears the status to 0x00 and raises busy_o from the next cycle. busy_o stays high for SECTOR_CYC cycles, or for 5*SECTOR_CYC cycles when erase_chip_i is 1.
- R10: In the cycle busy_o falls, erase_end_o is high for exactly one cycle and status bit 7 has been inverted. erase_end_bypass_o shows the value bypass_i had at that moment.
- R11: An erase_go_i that arrives while busy_o is high is ignored: the busy duration and the status are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Read mode from the decoder: 0 array, 1 identification, 2 query, 3 status |
| bypass_i | input | 1 | Bypass mode active in the decoder |
| rd_stb_i | input | 1 | One read per cycle that this is high |
| rd_off_i | input | 8 | Low byte of the read byte offset |
| rd_size_i | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| big_end_i | input | 1 | Byte order for array reads |
| arr_data_i | input | 32 | Four array bytes starting at the read offset |
| cfi_idx_o | output | 8 | Query table index |
| cfi_byte_i | input | 8 | Query table byte at cfi_idx_o |
| prog_done_i | input | 1 | Program completed (one-cycle pulse) |
| prog_msb_i | input | 1 | Bit 7 of the programmed data |
| erase_go_i | input | 1 | Start an erase (one-cycle pulse) |
| erase_chip_i | input | 1 | Erase kind: 1 chip, 0 sector |
| rd_data_o | output | 32 | Registered read data |
| rd_vld_o | output | 1 | Read data valid |
| busy_o | output | 1 | Erase timer running |
| erase_end_o | output | 1 | Pulse when the erase timer expires |
| erase_end_bypass_o | output | 1 | Resume the bypass command-wait state rather than read mode |

## Verification
The assertions check several rules on every cycle: the one-cycle valid timing, zero data for out-of-range query indexes and the protection index, zero upper bits on status reads, busy rising after an accepted erase, and the end pulse coinciding with busy falling. The bench scenarios are the only place that shows the rest. These include the exact values of the status byte across a sequence of programs, polls and timer expiry, the bit-6 toggle between successive polls, and the busy lengths for both erase kinds. They also cover rejection of a second erase mid-run and the byte packing and identification fallback across random offsets and sizes.

// File: rtl/frr_pkg.sv
package frr_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_CFI    = 2'd2,
    RM_STATUS = 2'd3
  } rd_mode_e;

  // raw: byte k is the byte at offset+k
  function automatic logic [31:0] pack_bytes(input logic [31:0] raw,
                                             input logic [1:0]  sz,
                                             input logic        be);
    logic [31:0] r;
    unique case (sz)
      2'd0:    r = {24'd0, raw[7:0]};
      2'd1:    r = be ? {16'd0, raw[7:0], raw[15:8]}
                      : {16'd0, raw[15:8], raw[7:0]};
      default: r = be ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]}
                      : raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/frr_busy_timer.sv
module frr_busy_timer #(
  parameter int SECTOR_CYC = 200,
  parameter int CHIP_MULT  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic chip,
  output logic busy,
  output logic expire
);
  localparam int CHIP_CYC = CHIP_MULT * SECTOR_CYC;
  localparam int CW       = $clog2(CHIP_CYC + 1);
  localparam logic [CW-1:0] SEC_LOAD  = CW'(SECTOR_CYC - 1);
  localparam logic [CW-1:0] CHIP_LOAD = CW'(CHIP_CYC - 1);

  logic [CW-1:0] cnt;

  assign expire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= chip ? CHIP_LOAD : SEC_LOAD;
      end
    end else if (expire) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/frr_status.sv
module frr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       prog_done,
  input  logic       prog_msb,
  input  logic       erase_start,
  input  logic       expire,
  input  logic       poll,
  output logic [7:0] status
);
  logic [7:0] nxt;

  always_comb begin
    nxt = status;
    if (expire) nxt[7] = ~nxt[7];
    if (poll)   nxt[6] = ~nxt[6];
    if (erase_start) nxt = 8'h00;
    if (prog_done)   nxt = {~prog_msb, 7'h7F};
  end

  always_ff @(posedge clk) begin
    if (rst) status <= 8'h00;
    else     status <= nxt;
  end
endmodule

// File: rtl/frr_data_sel.sv
module frr_data_sel
  import frr_pkg::*;
#(
  parameter int          CFI_LEN  = 82,
  parameter logic [15:0] MFR_ID   = 16'h0001,
  parameter logic [15:0] DEV_ID   = 16'h22C9,
  parameter logic [15:0] EXT_ID_A = 16'h00FF,
  parameter logic [15:0] EXT_ID_B = 16'h00FF
) (
  input  rd_mode_e    mode,
  input  logic [7:0]  idx,
  input  logic [31:0] raw,
  input  logic [1:0]  sz,
  input  logic        be,
  input  logic [7:0]  cfi_byte,
  input  logic [7:0]  status,
  output logic [31:0] data
);
  localparam logic [15:0] NO_ID = 16'h00FF;

  logic [31:0] arr_word;
  assign arr_word = pack_bytes(raw, sz, be);

  always_comb begin
    data = arr_word;
    unique case (mode)
      RM_IDENT: begin
        unique case (idx)
          8'h00: data = {16'd0, MFR_ID};
          8'h01: data = {16'd0, DEV_ID};
          8'h02: data = 32'd0;
          8'h0E: if (EXT_ID_A != NO_ID) data = {16'd0, EXT_ID_A};
          8'h0F: if (EXT_ID_B != NO_ID) data = {16'd0, EXT_ID_B};
          default: data = arr_word;
        endcase
      end
      RM_CFI:    data = (int'(idx) < CFI_LEN) ? {24'd0, cfi_byte} : 32'd0;
      RM_STATUS: data = {24'd0, status};
      default:   data = arr_word;
    endcase
  end
endmodule

// File: rtl/flash_rd_resp.sv
module flash_rd_resp
  import frr_pkg::*;
#(
  parameter int          BUS_BYTES  = 2,
  parameter int          CFI_LEN    = 82,
  parameter int          SECTOR_CYC = 200,
  parameter logic [15:0] MFR_ID     = 16'h0001,
  parameter logic [15:0] DEV_ID     = 16'h22C9,
  parameter logic [15:0] EXT_ID_A   = 16'h2210,
  parameter logic [15:0] EXT_ID_B   = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  mode_i,
  input  logic        bypass_i,
  input  logic        rd_stb_i,
  input  logic [7:0]  rd_off_i,
  input  logic [1:0]  rd_size_i,
  input  logic        big_end_i,
  input  logic [31:0] arr_data_i,
  output logic [7:0]  cfi_idx_o,
  input  logic [7:0]  cfi_byte_i,
  input  logic        prog_done_i,
  input  logic        prog_msb_i,
  input  logic        erase_go_i,
  input  logic        erase_chip_i,
  output logic [31:0] rd_data_o,
  output logic        rd_vld_o,
  output logic        busy_o,
  output logic        erase_end_o,
  output logic        erase_end_bypass_o
);
  localparam int SH = $clog2(BUS_BYTES);

  rd_mode_e    mode;
  logic [7:0]  idx;
  logic [7:0]  status;
  logic [31:0] sel_data;
  logic        expire;
  logic        go_ok;
  logic        poll;

  assign mode      = rd_mode_e'(mode_i);
  assign idx       = rd_off_i >> SH;
  assign cfi_idx_o = idx;
  assign go_ok     = erase_go_i && !busy_o;
  assign poll      = rd_stb_i && (mode == RM_STATUS);

  frr_busy_timer #(.SECTOR_CYC(SECTOR_CYC), .CHIP_MULT(5)) u_tmr (
    .clk(clk), .rst(rst), .start(go_ok), .chip(erase_chip_i),
    .busy(busy_o), .expire(expire)
  );

  frr_status u_st (
    .clk(clk), .rst(rst), .prog_done(prog_done_i), .prog_msb(prog_msb_i),
    .erase_start(go_ok), .expire(expire), .poll(poll), .status(status)
  );

  frr_data_sel #(
    .CFI_LEN(CFI_LEN), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
    .EXT_ID_A(EXT_ID_A), .EXT_ID_B(EXT_ID_B)
  ) u_sel (
    .mode(mode), .idx(idx), .raw(arr_data_i), .sz(rd_size_i),
    .be(big_end_i), .cfi_byte(cfi_byte_i), .status(status), .data(sel_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o          <= '0;
      rd_vld_o           <= 1'b0;
      erase_end_o        <= 1'b0;
      erase_end_bypass_o <= 1'b0;
    end else begin
      rd_vld_o    <= rd_stb_i;
      erase_end_o <= expire;
      if (rd_stb_i) rd_data_o <= sel_data;
      if (expire)   erase_end_bypass_o <= bypass_i;
    end
  end
endmodule

// File: rtl/frr_checker.sv
module frr_checker #(
  parameter int CFI_LEN = 82
) (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode_i,
  input logic        rd_stb_i,
  input logic [7:0]  cfi_idx_o,
  input logic        erase_go_i,
  input logic [31:0] rd_data_o,
  input logic        rd_vld_o,
  input logic        busy_o,
  input logic        erase_end_o
);
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> rd_vld_o);
  a_r2_vld_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> !rd_vld_o);
  a_r4_prot_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && mode_i == 2'd1 && cfi_idx_o == 8'h02) |=> rd_data_o == 32'd0);
  a_r6_cfi_beyond: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && mode_i == 2'd2 && int'(cfi_idx_o) >= CFI_LEN) |=> rd_data_o == 32'd0);
  a_r7_status_byte: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && mode_i == 2'd3) |=> rd_data_o[31:8] == 24'd0);
  a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
    (erase_go_i && !busy_o) |=> busy_o);
  a_r10_end_pulse: assert property (@(posedge clk) disable iff (rst)
    erase_end_o |-> (!busy_o && $past(busy_o)));
endmodule

bind flash_rd_resp frr_checker #(.CFI_LEN(CFI_LEN)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i), .rd_stb_i(rd_stb_i),
  .cfi_idx_o(cfi_idx_o), .erase_go_i(erase_go_i), .rd_data_o(rd_data_o),
  .rd_vld_o(rd_vld_o), .busy_o(busy_o), .erase_end_o(erase_end_o)
);

// File: tb/sim_flash_rd_resp.sv
`timescale 1ns/1ps
module sim_flash_rd_resp;
  localparam int          BB   = 2;
  localparam int          CLEN = 82;
  localparam int          SEC  = 20;
  localparam logic [15:0] MFR  = 16'h0001;
  localparam logic [15:0] DEV  = 16'h22C9;
  localparam logic [15:0] EXA  = 16'h2210;
  localparam logic [15:0] EXB  = 16'h00FF;

  logic        clk = 0, rst = 1;
  logic [1:0]  mode_i = 0;
  logic        bypass_i = 0, rd_stb_i = 0, big_end_i = 0;
  logic [7:0]  rd_off_i = 0;
  logic [1:0]  rd_size_i = 0;
  logic [31:0] arr_data_i;
  logic [7:0]  cfi_idx_o, cfi_byte_i;
  logic        prog_done_i = 0, prog_msb_i = 0, erase_go_i = 0, erase_chip_i = 0;
  logic [31:0] rd_data_o;
  logic        rd_vld_o, busy_o, erase_end_o, erase_end_bypass_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] st;

  always #4 clk = ~clk;

  function automatic logic [31:0] arr_word(input logic [7:0] o);
    return {o ^ 8'hC3, o + 8'h11, o ^ 8'h5A, ~o};
  endfunction
  function automatic logic [7:0] cfi_rom(input logic [7:0] i);
    return i ^ 8'hA5;
  endfunction

  assign arr_data_i = arr_word(rd_off_i);
  assign cfi_byte_i = cfi_rom(cfi_idx_o);

  flash_rd_resp #(.BUS_BYTES(BB), .CFI_LEN(CLEN), .SECTOR_CYC(SEC),
    .MFR_ID(MFR), .DEV_ID(DEV), .EXT_ID_A(EXA), .EXT_ID_B(EXB)) u0 (.*);

  function automatic logic [31:0] exp_arr(input logic [7:0] o, input logic [1:0] sz,
                                          input logic be);
    logic [31:0] w = arr_word(o);
    case (sz)
      2'd0:    return {24'd0, w[7:0]};
      2'd1:    return be ? {16'd0, w[7:0], w[15:8]} : {16'd0, w[15:8], w[7:0]};
      default: return be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] m, input logic [7:0] o,
                                           input logic [1:0] sz, input logic be);
    logic [7:0] i = o / BB;
    if (m == 2'd1) begin
      if (i == 0) return {16'd0, MFR};
      if (i == 1) return {16'd0, DEV};
      if (i == 2) return 0;
      if (i == 8'h0E && EXA != 16'h00FF) return {16'd0, EXA};
      if (i == 8'h0F && EXB != 16'h00FF) return {16'd0, EXB};
      return exp_arr(o, sz, be);
    end
    if (m == 2'd2) return (int'(i) < CLEN) ? {24'd0, cfi_rom(i)} : 0;
    return exp_arr(o, sz, be);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] m, input logic [7:0] o,
                         input logic [1:0] sz, input logic be, output logic [31:0] d);
    mode_i = m; rd_off_i = o; rd_size_i = sz; big_end_i = be; rd_stb_i = 1;
    @(negedge clk);
    rd_stb_i = 0;
    d = rd_data_o;
    chk("R2 valid", {31'd0, rd_vld_o}, 1);
  endtask

  task automatic prog(input logic msb);
    prog_done_i = 1; prog_msb_i = msb;
    @(negedge clk);
    prog_done_i = 0;
    st = {~msb, 7'h7F};
  endtask

  task automatic poll_chk(input string req);
    logic [31:0] d;
    do_read(2'd3, 8'h00, 2'd0, 1'b0, d);
    chk(req, d, {24'd0, st});
    st[6] = ~st[6];
  endtask

  initial begin
    int cnt;
    logic [31:0] d;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    chk("R1 data", rd_data_o, 0);
    chk("R1 valid", {31'd0, rd_vld_o}, 0);
    chk("R1 busy", {31'd0, busy_o}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 end", {31'd0, erase_end_o}, 0);
    st = 8'h00;
    poll_chk("R1 status zero");
    @(negedge clk);
    chk("R2 valid drops", {31'd0, rd_vld_o}, 0);
    chk("R2 data held", rd_data_o, 0);

    // directed identification and query corners
    do_read(2'd1, 8'h00, 2'd1, 0, d); chk("R4 mfr", d, {16'd0, MFR});
    do_read(2'd1, 8'h02, 2'd1, 0, d); chk("R4 dev", d, {16'd0, DEV});
    do_read(2'd1, 8'h04, 2'd1, 0, d); chk("R4 prot", d, 0);
    do_read(2'd1, 8'h1C, 2'd1, 0, d); chk("R5 extA", d, {16'd0, EXA});
    do_read(2'd1, 8'h1E, 2'd1, 1, d); chk("R5 extB fallback", d, exp_arr(8'h1E, 2'd1, 1));
    do_read(2'd1, 8'h0A, 2'd2, 0, d); chk("R5 other fallback", d, exp_arr(8'h0A, 2'd2, 0));
    do_read(2'd2, 8'h20, 2'd0, 0, d); chk("R6 query", d, {24'd0, cfi_rom(8'h10)});
    do_read(2'd2, 8'(2*(CLEN-1)), 2'd0, 0, d); chk("R6 last", d, {24'd0, cfi_rom(8'(CLEN-1))});
    do_read(2'd2, 8'(2*CLEN), 2'd0, 0, d); chk("R6 beyond", d, 0);
    do_read(2'd0, 8'h37, 2'd2, 1, d); chk("R3 be4", d, exp_arr(8'h37, 2'd2, 1));
    do_read(2'd0, 8'h37, 2'd3, 0, d); chk("R3 le4 code3", d, exp_arr(8'h37, 2'd3, 0));

    // random reads over the three data modes
    for (int k = 0; k < 300; k++) begin
      logic [1:0] m  = 2'($urandom_range(0, 2));
      logic [7:0] o  = 8'($urandom);
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic       be = 1'($urandom);
      do_read(m, o, sz, be, d);
      chk(m == 0 ? "R3 random" : (m == 1 ? "R5 random" : "R6 random"), d, exp_read(m, o, sz, be));
    end

    // program status and polling toggle
    prog(1'b1);
    poll_chk("R8 prog msb1");
    poll_chk("R7 toggle");
    poll_chk("R7 toggle back");
    prog(1'b0);
    poll_chk("R8 prog msb0");

    // sector erase with polls, then completion
    erase_chip_i = 0; erase_go_i = 1;
    @(negedge clk);
    erase_go_i = 0; st = 8'h00;
    chk("R9 busy rises", {31'd0, busy_o}, 1);
    poll_chk("R9 cleared");
    poll_chk("R7 busy toggle");
    cnt = 0;
    while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R10 end pulse", {31'd0, erase_end_o}, 1);
    chk("R10 resume read", {31'd0, erase_end_bypass_o}, 0);
    st[7] = ~st[7];
    @(negedge clk);
    chk("R10 single pulse", {31'd0, erase_end_o}, 0);
    poll_chk("R10 bit7 flip");

    // sector erase duration with a rejected second start
    erase_chip_i = 0; erase_go_i = 1;
    @(negedge clk);
    erase_go_i = 0;
    cnt = 0;
    while (busy_o && cnt < 1000) begin
      cnt++;
      if (cnt == 5) begin erase_go_i = 1; erase_chip_i = 1; end
      else erase_go_i = 0;
      @(negedge clk);
    end
    erase_go_i = 0;
    chk("R11 length kept", cnt, SEC);
    st = 8'h80;
    poll_chk("R11 status kept");

    // chip erase with bypass
    bypass_i = 1; erase_chip_i = 1; erase_go_i = 1;
    @(negedge clk);
    erase_go_i = 0;
    cnt = 0;
    while (busy_o && cnt < 1000) begin cnt++; @(negedge clk); end
    chk("R9 chip length", cnt, 5*SEC);
    chk("R10 bypass resume", {31'd0, erase_end_bypass_o}, 1);
    bypass_i = 0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule